// File: doc/BRIEF.md
# Serial Flash Write-Protection Status Guard

This block keeps the writable part of a serial flash status register and rules on every write-type instruction that the command decoder hands it. Each decoded instruction arrives as a one-cycle pulse together with its operation code, a target address and a data byte. One cycle later the block answers. For a program or erase request it raises either a grant or a deny pulse. For a status-register write it raises a grant pulse and loads the new protection fields in that same cycle.

Four block-protect bits pick a region at the top of the array, and address checks are made against that region. A lock bit, together with the active-low write-protect pin, can freeze the protection fields. A status write is only considered when the instruction immediately before it armed the register. The arming is tracked by a two-state machine. `ARM_IDLE` is the reset state. Transition *arm* goes to `ARM_READY` on a WREN or arm-status instruction. Transition *consume* returns to `ARM_IDLE` on any other instruction. While `ARM_READY` is held, another arming instruction is the self-loop *re-arm*. Cycles with no instruction keep the current state.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the block-protect field is 4'b1111, the lock bit is 0, and op_grant, op_deny and sr_wr_grant are 0.
- R2: status_byte carries busy_in at bit 0, wel at bit 1, BP0..BP3 at bits 2..5 (BP0 at bit 2), aai_in at bit 6 and the lock bit at bit 7. Bits 0, 1 and 6 follow their inputs directly.
- R3: instr_code is decoded as follows: 0 none, 1 WREN, 2 arm-status, 3 status write, 4 program, 5 sector/block erase, 6 chip erase, 7 other. Every answer appears one clock after the instr_valid cycle.
- R4: A status write (code 3) is granted only when the instruction immediately before it was code 1 or code 2. On a grant, wr_data[5:2] loads BP3..BP0 and wr_data[7] loads the lock bit. The new status_byte is visible in the cycle of the grant pulse.
- R5: The arming lasts for exactly one following instruction. Any instruction other than code 1 or 2 clears it, whether or not that instruction was granted. Idle cycles do not clear it.
- R6: When wp_n is 0 and the lock bit is 1, a status write is refused and the status bits are unchanged. With wp_n at 1, the same write is accepted.
- R7: BP code 1 protects the upper 1/16 of the address space, code 2 the upper 1/8, code 3 the upper 1/4 and code 4 the upper 1/2. Code 0 protects nothing.
- R8: Any BP code of 5 or above protects the entire array.
- R9: A program or sector/block erase is denied when its address lies in the protected region or wel is 0. Otherwise it is granted.
- R10: A chip erase is granted only when wel is 1 and all four BP bits are 0. Otherwise it is denied.
- R11: op_grant and op_deny are never high together. No answer pulse appears unless an instruction was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle pulse marking a decoded instruction |
| instr_code | input | 3 | Operation code (see R3) |
| addr | input | ADDR_W | Target address of program/erase |
| wr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| wel | input | 1 | Write-enable latch |
| busy_in | input | 1 | Busy flag shown in status bit 0 |
| aai_in | input | 1 | Auto-increment program mode flag shown in status bit 6 |
| status_byte | output | 8 | Current status register value |
| op_grant | output | 1 | Program/erase permitted (pulse) |
| op_deny | output | 1 | Program/erase refused (pulse) |
| sr_wr_grant | output | 1 | Status write accepted (pulse) |

## Verification
The bench builds the block with ADDR_W = 8 and FRACTIONS = 4, so every region boundary is a small address. The 1/16 boundary falls at 0xF0, the 1/8 boundary at 0xE0, the 1/4 boundary at 0xC0 and the 1/2 boundary at 0x80. With these values, the addresses just inside and just outside each boundary can be probed directly. Every BP code can be set and measured against an independent size computation. This includes the codes above the full-array level.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_WREN      = 3'd1,
        OP_ARMSR     = 3'd2,
        OP_WRSR      = 3'd3,
        OP_PROG      = 3'd4,
        OP_ERASE     = 3'd5,
        OP_CHIPERASE = 3'd6,
        OP_OTHER     = 3'd7
    } op_e;

    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_e;

    localparam int BP_W     = 4;
    localparam int SB_BUSY  = 0;
    localparam int SB_WEL   = 1;
    localparam int SB_BP_LO = 2;
    localparam int SB_AAI   = 6;
    localparam int SB_LOCK  = 7;

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int ADDR_W    = 20,
    parameter int FRACTIONS = 4,
    parameter int CODE_W    = 4
) (
    input  logic [CODE_W-1:0] bp_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region
);
    localparam int LEVELS = 1 << CODE_W;

    logic [LEVELS-1:0] hit;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        if (k == 0) begin : g_none
            assign hit[k] = 1'b0;
        end else if (k <= FRACTIONS) begin : g_part
            localparam int TOPBITS = FRACTIONS + 1 - k;
            assign hit[k] = &addr[ADDR_W-1 -: TOPBITS];
        end else begin : g_all
            assign hit[k] = 1'b1;
        end
    end

    assign in_region = hit[bp_code];

endmodule

// File: rtl/wp_arm_fsm.sv
module wp_arm_fsm
    import wp_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  op_e  op,
    output logic armed
);
    arm_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (instr_valid) begin
            unique case (state_q)
                ARM_IDLE:  state_d = (op == OP_WREN || op == OP_ARMSR) ? ARM_READY : ARM_IDLE;
                ARM_READY: state_d = (op == OP_WREN || op == OP_ARMSR) ? ARM_READY : ARM_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ARM_IDLE:  armed = 1'b0;
            ARM_READY: armed = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int FRACTIONS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_code,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              wel,
    input  logic              busy_in,
    input  logic              aai_in,
    output logic [7:0]        status_byte,
    output logic              op_grant,
    output logic              op_deny,
    output logic              sr_wr_grant
);
    op_e              op;
    logic             armed;
    logic             in_region;
    logic [BP_W-1:0]  bp_q;
    logic             lock_q;
    logic             is_pe, is_ce, sr_ok, pe_ok, ce_ok;
    logic             grant_d, deny_d;

    assign op = op_e'(instr_code);

    wp_arm_fsm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .op          (op),
        .armed       (armed)
    );

    wp_range_decode #(
        .ADDR_W    (ADDR_W),
        .FRACTIONS (FRACTIONS),
        .CODE_W    (BP_W)
    ) u_range (
        .bp_code   (bp_q),
        .addr      (addr),
        .in_region (in_region)
    );

    always_comb begin
        is_pe   = instr_valid && (op == OP_PROG || op == OP_ERASE);
        is_ce   = instr_valid && (op == OP_CHIPERASE);
        sr_ok   = instr_valid && (op == OP_WRSR) && armed && (wp_n || !lock_q);
        pe_ok   = is_pe && wel && !in_region;
        ce_ok   = is_ce && wel && (bp_q == '0);
        grant_d = pe_ok || ce_ok;
        deny_d  = (is_pe || is_ce) && !grant_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q        <= '1;
            lock_q      <= 1'b0;
            op_grant    <= 1'b0;
            op_deny     <= 1'b0;
            sr_wr_grant <= 1'b0;
        end else begin
            op_grant    <= grant_d;
            op_deny     <= deny_d;
            sr_wr_grant <= sr_ok;
            if (sr_ok) begin
                bp_q   <= wr_data[SB_BP_LO +: BP_W];
                lock_q <= wr_data[SB_LOCK];
            end
        end
    end

    always_comb begin
        status_byte                   = '0;
        status_byte[SB_BUSY]          = busy_in;
        status_byte[SB_WEL]           = wel;
        status_byte[SB_BP_LO +: BP_W] = bp_q;
        status_byte[SB_AAI]           = aai_in;
        status_byte[SB_LOCK]          = lock_q;
    end

endmodule

// File: rtl/wp_status_guard_chk.sv
module wp_status_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [2:0] instr_code,
    input logic       wp_n,
    input logic [7:0] status_byte,
    input logic       op_grant,
    input logic       op_deny,
    input logic       sr_wr_grant
);
    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_byte[5:2] == 4'hF && !status_byte[7]));

    // R6
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_code == 3'd3 && !wp_n && status_byte[7]) |=> !sr_wr_grant);

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_grant |-> ($stable(status_byte[5:2]) && $stable(status_byte[7])));

    // R10
    chip_erase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_code == 3'd6 && status_byte[5:2] != 4'd0) |=> !op_grant);

    // R11
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant && op_deny));

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !(op_grant || op_deny || sr_wr_grant));

endmodule

bind wp_status_guard wp_status_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_code  (instr_code),
    .wp_n        (wp_n),
    .status_byte (status_byte),
    .op_grant    (op_grant),
    .op_deny     (op_deny),
    .sr_wr_grant (sr_wr_grant)
);

// File: tb/wp_status_guard_tb_top.sv
module wp_status_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [2:0]    instr_code = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wp_n = 1'b1;
    logic          wel = 1'b0;
    logic          busy_in = 1'b0;
    logic          aai_in = 1'b0;
    logic [7:0]    status_byte;
    logic          op_grant, op_deny, sr_wr_grant;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_status_guard #(.ADDR_W(AW), .FRACTIONS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_code(instr_code),
        .addr(addr), .wr_data(wr_data), .wp_n(wp_n), .wel(wel), .busy_in(busy_in),
        .aai_in(aai_in), .status_byte(status_byte), .op_grant(op_grant),
        .op_deny(op_deny), .sr_wr_grant(sr_wr_grant)
    );

    typedef struct {
        logic [2:0] resp;   // {op_grant, op_deny, sr_wr_grant}
        int         due;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // bench model of the requirements
    logic [3:0] m_bp = 4'hF;
    logic       m_lock = 1'b0;
    bit         m_armed = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit prot(input logic [AW-1:0] a, input logic [3:0] bp);
        int size;
        if (bp == 4'd0) return 1'b0;
        if (bp >= 4'd5) return 1'b1;
        size = 256 >> (5 - int'(bp));
        return int'(a) >= 256 - size;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic issue(input logic [2:0] code, input logic [AW-1:0] a,
                         input logic [7:0] d, input string tag);
        exp_t e;
        bit g, dn, s;
        g = 0; dn = 0; s = 0;
        if (code == 3'd3 && m_armed && (wp_n || !m_lock)) s = 1;
        if (code == 3'd4 || code == 3'd5) begin
            g = wel && !prot(a, m_bp);
            dn = !g;
        end
        if (code == 3'd6) begin
            g = wel && (m_bp == 4'd0);
            dn = !g;
        end
        if (s) begin
            m_bp = d[5:2];
            m_lock = d[7];
        end
        m_armed = (code == 3'd1 || code == 3'd2);
        e.resp = {g, dn, s};
        e.due = cyc + 1;
        e.tag = tag;
        exp_q.push_back(e);
        instr_valid = 1'b1;
        instr_code = code;
        addr = a;
        wr_data = d;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_code = 3'd0;
    endtask

    task automatic check_status(input string tag);
        logic [7:0] ex;
        ex = {m_lock, aai_in, m_bp, wel, busy_in};
        check(status_byte == ex, tag, status_byte, ex);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({op_grant, op_deny, sr_wr_grant} == e.resp, e.tag,
                          {op_grant, op_deny, sr_wr_grant}, e.resp);
                end else if (op_grant || op_deny || sr_wr_grant) begin
                    check(1'b0, "R11 spurious pulse", {op_grant, op_deny, sr_wr_grant}, 0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status_byte == 8'h3C && !op_grant && !op_deny && !sr_wr_grant,
              "R1 reset state", status_byte, 8'h3C);
        rst_n = 1'b1;
        @(negedge clk);
        check_status("R1 power-up status");

        busy_in = 1; aai_in = 1; wel = 1;
        #1 check_status("R2 layout busy/aai/wel high");
        busy_in = 0; aai_in = 0; wel = 0;
        #1 check_status("R2 layout low");
        wel = 1;

        issue(3'd4, 8'h00, 8'h00, "R8 program with all protected");
        issue(3'd6, 8'h00, 8'h00, "R10 chip erase refused BP=F");
        issue(3'd3, 8'h00, 8'h00, "R4 unarmed status write refused");
        check_status("R4 status unchanged");
        issue(3'd7, 8'h00, 8'h00, "R3 other code no answer");

        issue(3'd1, 8'h00, 8'h00, "R3 WREN no answer");
        issue(3'd3, 8'h00, 8'h00, "R4 status write after WREN");
        check_status("R4 BP cleared");
        issue(3'd4, 8'h00, 8'h00, "R9 program unprotected");
        issue(3'd6, 8'h00, 8'h00, "R10 chip erase granted");
        wel = 0;
        @(negedge clk);
        issue(3'd4, 8'h00, 8'h00, "R9 program without wel");
        issue(3'd6, 8'h00, 8'h00, "R10 chip erase without wel");
        wel = 1;
        @(negedge clk);

        for (int L = 1; L <= 4; L++) begin
            logic [AW-1:0] bnd;
            bnd = 8'(256 - (256 >> (5 - L)));
            issue(3'd2, 8'h00, 8'h00, "R4 arm");
            issue(3'd3, 8'h00, 8'(L << 2), "R4 set level");
            check_status("R7 level loaded");
            issue(3'd4, bnd, 8'h00, "R7 lowest protected address");
            issue(3'd5, bnd - 8'd1, 8'h00, "R7 erase just below region");
            issue(3'd4, 8'hFF, 8'h00, "R7 top address");
            issue(3'd6, 8'h00, 8'h00, "R10 chip erase with partial region");
        end

        for (int L = 5; L <= 15; L += 2) begin
            issue(3'd2, 8'h00, 8'h00, "R4 arm");
            issue(3'd3, 8'h00, 8'(L << 2), "R8 set high level");
            issue(3'd4, 8'h00, 8'h00, "R8 bottom address protected");
        end

        issue(3'd2, 8'h00, 8'h00, "R5 arm");
        issue(3'd0, 8'h00, 8'h00, "R5 none code consumes arm");
        issue(3'd3, 8'h00, 8'h00, "R5 write after intervening instr");
        check_status("R5 status unchanged");
        issue(3'd1, 8'h00, 8'h00, "R5 arm");
        repeat (3) @(negedge clk);
        issue(3'd3, 8'h00, 8'h04, "R5 arm survives idle");
        check_status("R5 write after idle");
        issue(3'd3, 8'h00, 8'h00, "R5 second write refused");

        issue(3'd2, 8'h00, 8'h00, "R6 arm");
        issue(3'd3, 8'h00, 8'h84, "R6 set lock with pin high");
        check_status("R6 lock set");
        wp_n = 0;
        @(negedge clk);
        issue(3'd2, 8'h00, 8'h00, "R6 arm");
        issue(3'd3, 8'h00, 8'h00, "R6 locked write refused");
        check_status("R6 status frozen");
        wp_n = 1;
        @(negedge clk);
        issue(3'd2, 8'h00, 8'h00, "R6 arm");
        issue(3'd3, 8'h00, 8'h00, "R6 write with pin high accepted");
        check_status("R6 unlocked");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule